// File: doc/BRIEF.md
# Sixteen-Bit Reload/Capture Timer with Square-Wave Output

This block is a 16-bit timer/counter with a companion 16-bit reload/capture register. It advances either once per machine-cycle tick (timer) or once per falling edge on its count pin (counter). It has four operating modes:

- **Auto-reload:** counts up, or up and down with the direction taken from the external pin.
- **Capture:** the count is latched into the companion register on an external falling edge.
- **Baud generation:** overflows become a tick for a serial port.
- **Clock-out:** overflows toggle a square wave that drives the count pin.

Software-side access is reduced to plain ports. The configuration bits are static level inputs. Write strobes load the count and the reload value. Clear strobes reset the two sticky flags. The surrounding register file owns the addresses.

The mode bits are decoded with a fixed precedence: clock-out first, then baud generation, then capture, then auto-reload. Pin edges are detected every clock against the previous clock's sample, and act in the following cycle.

Top module: `aux_timer16`

## Requirements
- R1: After reset the count, the reload/capture value, both flags, the square-wave output and the baud tick are all zero.
- R2: While `runEn` is low the count does not change (apart from a software count write).
- R3: With `ctrSel` low the count advances by one for each cycle in which `tick` is high. With `ctrSel` high it advances once per falling edge of `t2Pin` (a 1 sample followed by a 0 sample), and `tick` has no effect.
- R4: In auto-reload mode (`capSel`=0, `upDown`=0), counting up past 0xFFFF loads the reload value and sets `ovfFlag`.
- R5: In auto-reload mode with `upDown`=1, the count goes up while `t2exPin` is 1 and down while it is 0.
- R6: Counting down, if the decremented value equals the reload value the count becomes 0xFFFF instead, `ovfFlag` is set and `extFlag` toggles. In up/down mode an upward wrap reloads, sets `ovfFlag` and also toggles `extFlag`.
- R7: In capture mode (`capSel`=1) with `extEn`=1, a `t2exPin` falling edge copies the current count into the reload/capture register and sets `extFlag`. A count overflow wraps to 0x0000 and sets `ovfFlag`.
- R8: In capture mode with `extEn`=0, a `t2exPin` falling edge leaves the reload/capture value and `extFlag` unchanged.
- R9: In clock-out mode (`clkOutEn`=1), each overflow reloads the count. Each overflow toggles `t2Out` when `ctrSel`=0. `t2OutEn` equals 1 exactly when `clkOutEn`=1 and `ctrSel`=0. `ovfFlag` is not set. A `t2exPin` falling edge sets `extFlag` when `extEn`=1.
- R10: When `rxBaud` or `txBaud` is 1 and clock-out is off, the mode is baud generation, even if `capSel`=1. Each overflow reloads the count and produces a one-cycle `baudTick` pulse in the next cycle. `ovfFlag` is not set.
- R11: Both flags stay set until their clear strobe. A set in the same cycle as a clear leaves the flag set.
- R12: A count write or reload write takes priority over counting and capture in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | Machine-cycle tick (timer mode count enable) |
| t2Pin | input | 1 | Count pin sample (counter mode source) |
| t2exPin | input | 1 | External pin sample (capture/direction/flag source) |
| runEn | input | 1 | Run enable |
| capSel | input | 1 | 1 = capture mode, 0 = auto-reload mode |
| ctrSel | input | 1 | 1 = count `t2Pin` falling edges, 0 = count ticks |
| extEn | input | 1 | Enables the external falling-edge actions |
| rxBaud | input | 1 | Receive baud-clock select |
| txBaud | input | 1 | Transmit baud-clock select |
| upDown | input | 1 | Enables up/down counting in auto-reload mode |
| clkOutEn | input | 1 | Enables square-wave clock-out mode |
| cntWrEn | input | 1 | Count write strobe |
| cntWrData | input | 16 | Count write value |
| rldWrEn | input | 1 | Reload/capture register write strobe |
| rldWrData | input | 16 | Reload/capture write value |
| clrOvf | input | 1 | Clears `ovfFlag` |
| clrExt | input | 1 | Clears `extFlag` |
| count | output | 16 | Current count |
| reloadVal | output | 16 | Reload/capture register |
| ovfFlag | output | 1 | Sticky overflow flag |
| extFlag | output | 1 | Sticky external flag |
| t2Out | output | 1 | Square-wave output level |
| t2OutEn | output | 1 | Drive enable for `t2Out` onto the count pin |
| baudTick | output | 1 | One-cycle pulse per baud-mode overflow |

## Verification
Every state change lands on the clock edge that samples its cause. A tick or write present at an edge shows in `count`, the flags and `t2Out` right after that edge. A pin's falling edge acts at the first edge that samples the low level, and `baudTick` is high for the single cycle following the wrapping edge.

The bench changes inputs only on falling clock edges and opens each counting window with `runEn`. It counts the rising edges inside the window exactly and reads results at the falling edge after the last one. Expected counts, wrap points and pulse totals are computed arithmetically from the start value, the reload value and the step count.

// File: rtl/auxt_pkg.sv
package auxt_pkg;

  typedef enum logic [1:0] {
    MODE_RELOAD  = 2'd0,
    MODE_CAPTURE = 2'd1,
    MODE_BAUD    = 2'd2,
    MODE_CLKOUT  = 2'd3
  } auxtMode_e;

  // Per-cycle strobes from control to datapath
  typedef struct packed {
    logic step;          // advance the count this cycle
    logic down;          // direction of the step
    logic wrapReload;    // upward wrap loads reload value (else zero)
    logic wrapFlag;      // wrap sets the overflow flag
    logic wrapToggleExt; // wrap toggles the external flag
    logic wrapToggleClk; // wrap toggles the square-wave bit
    logic wrapBaud;      // wrap emits a baud tick
    logic capture;       // copy count into reload/capture register
    logic setExt;        // set the external flag
  } auxtStrobe_t;

endpackage

// File: rtl/auxt_ctrl.sv
module auxt_ctrl
  import auxt_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        tick,
  input  logic        t2Pin,
  input  logic        t2exPin,
  input  logic        runEn,
  input  logic        capSel,
  input  logic        ctrSel,
  input  logic        extEn,
  input  logic        rxBaud,
  input  logic        txBaud,
  input  logic        upDown,
  input  logic        clkOutEn,
  output auxtStrobe_t strobe,
  output logic        t2OutEn
);

  logic prevT2, prevT2ex;
  logic t2Fall, exFall;
  auxtMode_e mode;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      prevT2   <= 1'b0;
      prevT2ex <= 1'b0;
    end else begin
      prevT2   <= t2Pin;
      prevT2ex <= t2exPin;
    end
  end

  assign t2Fall  = prevT2 & ~t2Pin;
  assign exFall  = prevT2ex & ~t2exPin;
  assign t2OutEn = clkOutEn & ~ctrSel;

  always_comb begin
    if (clkOutEn)              mode = MODE_CLKOUT;
    else if (rxBaud | txBaud)  mode = MODE_BAUD;
    else if (capSel)           mode = MODE_CAPTURE;
    else                       mode = MODE_RELOAD;
  end

  always_comb begin
    strobe      = '0;
    strobe.step = runEn & (ctrSel ? t2Fall : tick);
    unique case (mode)
      MODE_CLKOUT: begin
        strobe.wrapReload    = 1'b1;
        strobe.wrapToggleClk = ~ctrSel;
        strobe.setExt        = extEn & exFall;
      end
      MODE_BAUD: begin
        strobe.wrapReload = 1'b1;
        strobe.wrapBaud   = 1'b1;
        strobe.setExt     = extEn & exFall;
      end
      MODE_CAPTURE: begin
        strobe.wrapFlag = 1'b1;
        strobe.capture  = extEn & exFall;
        strobe.setExt   = extEn & exFall;
      end
      default: begin
        strobe.wrapReload    = 1'b1;
        strobe.wrapFlag      = 1'b1;
        strobe.down          = upDown & ~t2exPin;
        strobe.wrapToggleExt = upDown;
      end
    endcase
  end

endmodule

// File: rtl/auxt_datapath.sv
module auxt_datapath
  import auxt_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  auxtStrobe_t      strobe,
  input  logic             cntWrEn,
  input  logic [CNT_W-1:0] cntWrData,
  input  logic             rldWrEn,
  input  logic [CNT_W-1:0] rldWrData,
  input  logic             clrOvf,
  input  logic             clrExt,
  output logic [CNT_W-1:0] count,
  output logic [CNT_W-1:0] reloadVal,
  output logic             ovfFlag,
  output logic             extFlag,
  output logic             clkBit,
  output logic             baudTick
);

  localparam logic [CNT_W-1:0] ALL_ONES = {CNT_W{1'b1}};
  localparam logic [CNT_W-1:0] ONE      = CNT_W'(1);

  logic [CNT_W-1:0] decVal, incVal, countNext;
  logic upWrap, dnWrap, wrap;

  assign decVal = count - ONE;
  assign incVal = count + ONE;
  assign upWrap = strobe.step & ~strobe.down & (count == ALL_ONES);
  assign dnWrap = strobe.step & strobe.down & (decVal == reloadVal);
  assign wrap   = upWrap | dnWrap;

  always_comb begin
    if (cntWrEn)          countNext = cntWrData;
    else if (upWrap)      countNext = strobe.wrapReload ? reloadVal : '0;
    else if (dnWrap)      countNext = ALL_ONES;
    else if (strobe.step) countNext = strobe.down ? decVal : incVal;
    else                  countNext = count;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      count     <= '0;
      reloadVal <= '0;
      ovfFlag   <= 1'b0;
      extFlag   <= 1'b0;
      clkBit    <= 1'b0;
      baudTick  <= 1'b0;
    end else begin
      count <= countNext;
      if (rldWrEn)             reloadVal <= rldWrData;
      else if (strobe.capture) reloadVal <= count;
      if (wrap & strobe.wrapFlag) ovfFlag <= 1'b1;
      else if (clrOvf)            ovfFlag <= 1'b0;
      if (strobe.setExt)                   extFlag <= 1'b1;
      else if (wrap & strobe.wrapToggleExt) extFlag <= ~extFlag;
      else if (clrExt)                     extFlag <= 1'b0;
      if (wrap & strobe.wrapToggleClk) clkBit <= ~clkBit;
      baudTick <= wrap & strobe.wrapBaud;
    end
  end

endmodule

// File: rtl/aux_timer16.sv
module aux_timer16
  import auxt_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             tick,
  input  logic             t2Pin,
  input  logic             t2exPin,
  input  logic             runEn,
  input  logic             capSel,
  input  logic             ctrSel,
  input  logic             extEn,
  input  logic             rxBaud,
  input  logic             txBaud,
  input  logic             upDown,
  input  logic             clkOutEn,
  input  logic             cntWrEn,
  input  logic [CNT_W-1:0] cntWrData,
  input  logic             rldWrEn,
  input  logic [CNT_W-1:0] rldWrData,
  input  logic             clrOvf,
  input  logic             clrExt,
  output logic [CNT_W-1:0] count,
  output logic [CNT_W-1:0] reloadVal,
  output logic             ovfFlag,
  output logic             extFlag,
  output logic             t2Out,
  output logic             t2OutEn,
  output logic             baudTick
);

  auxtStrobe_t strobe;

  auxt_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .tick(tick), .t2Pin(t2Pin), .t2exPin(t2exPin),
    .runEn(runEn), .capSel(capSel), .ctrSel(ctrSel), .extEn(extEn),
    .rxBaud(rxBaud), .txBaud(txBaud), .upDown(upDown), .clkOutEn(clkOutEn),
    .strobe(strobe), .t2OutEn(t2OutEn)
  );

  auxt_datapath #(.CNT_W(CNT_W)) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe),
    .cntWrEn(cntWrEn), .cntWrData(cntWrData),
    .rldWrEn(rldWrEn), .rldWrData(rldWrData),
    .clrOvf(clrOvf), .clrExt(clrExt),
    .count(count), .reloadVal(reloadVal),
    .ovfFlag(ovfFlag), .extFlag(extFlag),
    .clkBit(t2Out), .baudTick(baudTick)
  );

endmodule

// File: rtl/aux_timer16_chk.sv
module aux_timer16_chk #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rstN,
  input logic             runEn,
  input logic             capSel,
  input logic             extEn,
  input logic             rxBaud,
  input logic             txBaud,
  input logic             clkOutEn,
  input logic             cntWrEn,
  input logic [CNT_W-1:0] cntWrData,
  input logic             rldWrEn,
  input logic             clrOvf,
  input logic [CNT_W-1:0] count,
  input logic [CNT_W-1:0] reloadVal,
  input logic             ovfFlag,
  input logic             t2Out
);

  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (!runEn && !cntWrEn) |=> $stable(count)); // R2

  AST_CAPTURE_GATED: assert property (@(posedge clk) disable iff (!rstN)
    (capSel && !extEn && !rldWrEn && !clkOutEn && !rxBaud && !txBaud) |=> $stable(reloadVal)); // R8

  AST_SQUARE_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !clkOutEn |=> $stable(t2Out)); // R9

  AST_BAUD_NO_FLAG: assert property (@(posedge clk) disable iff (!rstN)
    ((rxBaud || txBaud) && !clkOutEn && !ovfFlag) |=> !ovfFlag); // R10

  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    (ovfFlag && !clrOvf) |=> ovfFlag); // R11

  AST_WRITE_WINS: assert property (@(posedge clk) disable iff (!rstN)
    cntWrEn |=> (count == $past(cntWrData))); // R12

endmodule

bind aux_timer16 aux_timer16_chk #(.CNT_W(CNT_W)) u_chk (.*);

// File: tb/aux_timer16_tb.sv
`timescale 1ns/1ps
module aux_timer16_tb;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic tick = 0, t2Pin = 0, t2exPin = 0, runEn = 0, capSel = 0, ctrSel = 0;
  logic extEn = 0, rxBaud = 0, txBaud = 0, upDown = 0, clkOutEn = 0;
  logic cntWrEn = 0, rldWrEn = 0, clrOvf = 0, clrExt = 0;
  logic [15:0] cntWrData = 0, rldWrData = 0;
  logic [15:0] count, reloadVal;
  logic ovfFlag, extFlag, t2Out, t2OutEn, baudTick;

  int errors = 0;
  int checks = 0;

  always #2.5 clk = ~clk;

  aux_timer16 u_dut (.*);

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wrBoth(input logic [15:0] c, input logic [15:0] r);
    @(negedge clk);
    cntWrEn = 1; cntWrData = c; rldWrEn = 1; rldWrData = r;
    @(negedge clk);
    cntWrEn = 0; rldWrEn = 0;
  endtask

  task automatic clrFlags();
    @(negedge clk);
    clrOvf = 1; clrExt = 1;
    @(negedge clk);
    clrOvf = 0; clrExt = 0;
  endtask

  task automatic runN(input int n);
    @(negedge clk);
    runEn = 1; tick = 1;
    repeat (n) @(posedge clk);
    @(negedge clk);
    runEn = 0;
  endtask

  initial begin
    #500000;
    errors++; checks++;
    $display("FAIL watchdog: actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk);
    // R1 reset state
    chk("R1 count", count, 0);
    chk("R1 reloadVal", reloadVal, 0);
    chk("R1 flags", {ovfFlag, extFlag, t2Out, baudTick}, 0);

    // R2 idle while run is low
    wrBoth(16'h0321, 16'h0000);
    tick = 1;
    repeat (10) @(negedge clk);
    chk("R2 count held", count, 16'h0321);

    // R3/R4 timer mode up-count sweep with reload
    for (int i = 0; i < 4; i++) begin
      int start, rld, n, d, exp;
      start = 16'hFFF0 + i * 3;
      rld   = 16'h1234 + i * 16'h1111;
      n     = 12 + i * 4;
      d     = 65536 - start;
      exp   = (n < d) ? start + n : rld + (n - d);
      clrFlags();
      wrBoth(16'(start), 16'(rld));
      runN(n);
      chk("R3/R4 count", count, exp);
      chk("R4 ovfFlag", ovfFlag, (n >= d) ? 1 : 0);
    end

    // R3 counter mode: falling edges of t2Pin only
    for (int k = 3; k <= 7; k += 4) begin
      wrBoth(16'h0100, 16'h0000);
      ctrSel = 1; t2Pin = 0;
      @(negedge clk);
      runEn = 1; tick = 1;
      for (int p = 0; p < k; p++) begin
        @(negedge clk) t2Pin = 1;
        @(negedge clk) t2Pin = 0;
      end
      @(negedge clk);
      runEn = 0;
      chk("R3 counter edges", count, 16'h0100 + k);
    end
    ctrSel = 0;

    // R5/R6 up/down sweep
    upDown = 1;
    for (int i = 0; i < 3; i++) begin
      logic [15:0] rld;
      rld = (i == 0) ? 16'h0040 : (i == 1) ? 16'h8000 : 16'hFFF0;
      t2exPin = 0;
      clrFlags();
      wrBoth(rld + 16'd5, rld);
      runN(4);
      chk("R5 down count", count, rld + 16'd1);
      chk("R6 no early flag", ovfFlag, 0);
      runN(1);
      chk("R6 down wrap count", count, 16'hFFFF);
      chk("R6 down wrap flags", {ovfFlag, extFlag}, 2'b11);
      clrFlags();
      t2exPin = 1;
      runN(1);
      chk("R6 up wrap count", count, rld);
      chk("R6 up wrap flags", {ovfFlag, extFlag}, 2'b11);
      runN(3);
      chk("R5 up count", count, rld + 16'd3);
    end

    // R11 sticky and set-beats-clear
    repeat (5) @(negedge clk);
    chk("R11 ovf sticky", ovfFlag, 1);
    clrFlags();
    chk("R11 cleared", {ovfFlag, extFlag}, 0);
    t2exPin = 0;
    wrBoth(16'h0051, 16'h0050);
    @(negedge clk);
    runEn = 1; tick = 1; clrOvf = 1;
    @(negedge clk);
    runEn = 0; clrOvf = 0;
    chk("R11 set wins over clear", ovfFlag, 1);
    chk("R6 wrap in same cycle", count, 16'hFFFF);
    upDown = 0;

    // R7 capture on external falling edge
    capSel = 1; extEn = 1; t2exPin = 1;
    clrFlags();
    wrBoth(16'h1000, 16'h0000);
    @(negedge clk);
    runEn = 1; tick = 1;
    repeat (6) @(posedge clk);
    @(negedge clk) t2exPin = 0;
    @(posedge clk);
    @(negedge clk) runEn = 0;
    chk("R7 captured value", reloadVal, 16'h1006);
    chk("R7 count continues", count, 16'h1007);
    chk("R7 extFlag", extFlag, 1);

    // R7 capture overflow wraps to zero
    clrFlags();
    wrBoth(16'hFFFE, 16'h5555);
    runN(3);
    chk("R7 wrap to zero", count, 16'h0001);
    chk("R7 ovfFlag", ovfFlag, 1);

    // R8 external edge ignored without extEn
    extEn = 0; t2exPin = 1;
    clrFlags();
    @(negedge clk) t2exPin = 0;
    repeat (2) @(negedge clk);
    chk("R8 capture unchanged", reloadVal, 16'h5555);
    chk("R8 extFlag unchanged", extFlag, 0);
    capSel = 0;

    // R12 write beats counting
    @(negedge clk);
    runEn = 1; tick = 1; cntWrEn = 1; cntWrData = 16'h2222;
    @(negedge clk);
    runEn = 0; cntWrEn = 0;
    chk("R12 write wins", count, 16'h2222);

    // R9 clock-out square wave
    clkOutEn = 1; ctrSel = 0;
    clrFlags();
    wrBoth(16'hFFFC, 16'hFFFC);
    chk("R9 drive enable", t2OutEn, 1);
    for (int m = 1; m <= 4; m++) begin
      runN(4);
      chk("R9 square level", t2Out, m & 1);
      chk("R9 reload count", count, 16'hFFFC);
    end
    chk("R9 no ovfFlag", ovfFlag, 0);
    extEn = 1; t2exPin = 1;
    @(negedge clk) t2exPin = 0;
    @(negedge clk);
    chk("R9 ext edge flag", extFlag, 1);
    ctrSel = 1;
    @(negedge clk);
    chk("R9 drive off in counter", t2OutEn, 0);
    ctrSel = 0; clkOutEn = 0; extEn = 0;

    // R10 baud mode takes priority over capture
    rxBaud = 1; capSel = 1;
    clrFlags();
    wrBoth(16'hFFF8, 16'hFFF8);
    begin
      int pulses;
      pulses = 0;
      @(negedge clk);
      runEn = 1; tick = 1;
      for (int c = 0; c < 40; c++) begin
        @(posedge clk);
        @(negedge clk);
        if (baudTick) pulses++;
      end
      runEn = 0;
      @(negedge clk);
      if (baudTick) pulses++;
      chk("R10 baud pulses", pulses, 5);
    end
    chk("R10 reload count", count, 16'hFFF8);
    chk("R10 no ovfFlag", ovfFlag, 0);
    rxBaud = 0; txBaud = 1; capSel = 0;
    wrBoth(16'hFFFF, 16'h0007);
    runN(1);
    chk("R10 tx baud reload", count, 16'h0007);
    txBaud = 0;

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule